// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block gathers the four interrupt pins of every device slot on a PCI bus onto four shared interrupt lines, called PIRQ A to D. It then steers those shared lines onto a sixteen-input interrupt controller through four programmable routing bytes.

A device reports a change on one of its pins through an event interface. The event carries the device/function number, the pin index (0 = INTA to 3 = INTD) and the new level. The block rotates the pin by the slot number, so that devices in neighbouring slots spread their INTA pins over different shared lines. It then latches the new level on the shared line that the rotation picks.

Each shared line has a routing byte. The byte either names one controller input or leaves the line unconnected. Every controller input is the OR of all the shared lines routed to it. The routing bytes are written and read back through a small byte-wide register port.

Top module: `irq_pin_router`

## Requirements
- R1: The shared line hit by an event is (pin + slot − 1) mod 4, where slot = dev_devfn[7:3]. Pin 0 is INTA and pin 3 is INTD. Shared line 0 is A and line 3 is D. Slot 0 wraps, so its pin 0 lands on line 3.
- R2: On a clock edge with dev_valid high, the selected shared line takes the value of dev_level. The other three lines keep their values, and nothing changes while dev_valid is low.
- R3: The routing bytes of lines A, B, C and D sit at register addresses 0x60, 0x61, 0x62 and 0x63. A write with reg_we is stored at the next edge. reg_rdata returns the addressed byte combinationally, and any other address reads 0x00. Writes to any other address change no routing byte and no output.
- R4: A routing byte whose value is below 16 connects its line to ctl_irq[value].
- R5: A routing byte whose value is 16 or more, including any byte with bit 7 set, leaves its line connected to nothing.
- R6: ctl_irq[i] is the OR of the levels of all shared lines whose routing byte equals i.
- R7: A controller input that no line selects is driven low.
- R8: Reset clears all four line levels. With RESET_PROFILE = 0, every routing byte resets to 0x80. With RESET_PROFILE = 1, the bytes reset to 0x0A, 0x0A, 0x0B and 0x0B (A and B to input 10, C and D to input 11).
- R9: From the cycle after a routing write, the outputs follow the new mapping. The input the line was routed to before no longer carries its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_valid | input | 1 | Pin level event strobe |
| dev_devfn | input | 8 | Device/function number of the reporting device |
| dev_pin | input | 2 | Interrupt pin index, 0 = INTA to 3 = INTD |
| dev_level | input | 1 | New level of that pin |
| reg_we | input | 1 | Routing register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ctl_irq | output | 16 | Interrupt controller request vector |

## Verification
The situations hardest to reach from the ports are two lines sharing one controller input, and a route being moved while its line is held high. Both need a chosen set of routing writes and pin events in a given order. The bench keeps its own model of the latched levels and routing bytes. It sweeps all 32 slots by 4 pins with one-hot routing, every routing value for each line, and shared-input cases where the two lines toggle independently. It also moves a live route and checks that the old input drops in the same cycle as the new one rises.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int LINE_N  = 4;
    localparam int LINE_W  = 2;
    localparam int BYTE_W  = 8;

    typedef logic [BYTE_W-1:0] route_t;

    // Reset value of a routing byte for the chosen profile
    function automatic route_t default_route(input int profile, input int line);
        if (profile == 1) begin
            return (line < 2) ? route_t'(8'h0A) : route_t'(8'h0B);
        end
        return route_t'(8'h80);
    endfunction
endpackage

// File: rtl/irq_slot_swizzle.sv
module irq_slot_swizzle
    import irq_router_pkg::*;
#(
    parameter int DEVFN_W   = 8,
    parameter int FUNC_BITS = 3
) (
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [LINE_W-1:0]  pin,
    output logic [LINE_W-1:0]  line_idx
);
    logic [DEVFN_W-1:0] slot_num;
    logic [DEVFN_W-1:0] pin_ext;

    always_comb begin
        slot_num = devfn >> FUNC_BITS;
        pin_ext  = DEVFN_W'(pin);
        // modulo 4 falls out of the truncation
        line_idx = LINE_W'(pin_ext + slot_num - DEVFN_W'(1));
    end
endmodule

// File: rtl/irq_level_latch.sv
module irq_level_latch
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [LINE_W-1:0] ev_idx,
    input  logic              ev_level,
    output logic [LINE_N-1:0] levels
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            levels <= '0;
        end else if (ev_valid) begin
            levels[ev_idx] <= ev_level;
        end
    end

    assert_event_sets_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> levels[$past(ev_idx)] == $past(ev_level));

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> $stable(levels));
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_router_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int BASE_ADDR     = 'h60,
    parameter int RESET_PROFILE = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [BYTE_W-1:0]         wdata,
    output logic [BYTE_W-1:0]         rdata,
    output route_t [LINE_N-1:0]       routes
);
    logic [LINE_N-1:0] hit;

    for (genvar k = 0; k < LINE_N; k++) begin : g_reg
        assign hit[k] = (addr == ADDR_W'(BASE_ADDR + k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                routes[k] <= default_route(RESET_PROFILE, k);
            end else if (we && hit[k]) begin
                routes[k] <= wdata;
            end
        end

        assert_write_stores_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (we && addr == ADDR_W'(BASE_ADDR + k)) |=> routes[k] == $past(wdata));
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < LINE_N; k++) begin
            if (hit[k]) rdata = routes[k];
        end
    end

    assert_stray_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr < ADDR_W'(BASE_ADDR) || addr > ADDR_W'(BASE_ADDR + LINE_N - 1)))
        |=> $stable(routes));
endmodule

// File: rtl/irq_merge.sv
module irq_merge
    import irq_router_pkg::*;
#(
    parameter int OUT_N = 16
) (
    input  logic [LINE_N-1:0]   levels,
    input  route_t [LINE_N-1:0] routes,
    output logic [OUT_N-1:0]    irq_out
);
    localparam int OUT_W = $clog2(OUT_N);

    logic [LINE_N-1:0] live;

    for (genvar p = 0; p < LINE_N; p++) begin : g_live
        assign live[p] = levels[p] && (routes[p] < BYTE_W'(OUT_N));
    end

    for (genvar o = 0; o < OUT_N; o++) begin : g_out
        logic [LINE_N-1:0] sel;
        for (genvar p = 0; p < LINE_N; p++) begin : g_sel
            assign sel[p] = live[p] && (routes[p][OUT_W-1:0] == OUT_W'(o));
        end
        assign irq_out[o] = |sel;
    end
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
    import irq_router_pkg::*;
#(
    parameter int OUT_N         = 16,
    parameter int RESET_PROFILE = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dev_valid,
    input  logic [7:0]   dev_devfn,
    input  logic [1:0]   dev_pin,
    input  logic         dev_level,
    input  logic         reg_we,
    input  logic [7:0]   reg_addr,
    input  logic [7:0]   reg_wdata,
    output logic [7:0]   reg_rdata,
    output logic [OUT_N-1:0] ctl_irq
);
    logic [LINE_W-1:0]   ev_line;
    logic [LINE_N-1:0]   line_lvl;
    route_t [LINE_N-1:0] line_route;

    irq_slot_swizzle #(.DEVFN_W(8), .FUNC_BITS(3)) u_swz (
        .devfn    (dev_devfn),
        .pin      (dev_pin),
        .line_idx (ev_line)
    );

    irq_level_latch u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (dev_valid),
        .ev_idx   (ev_line),
        .ev_level (dev_level),
        .levels   (line_lvl)
    );

    irq_route_regs #(.ADDR_W(8), .BASE_ADDR('h60), .RESET_PROFILE(RESET_PROFILE)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .routes (line_route)
    );

    irq_merge #(.OUT_N(OUT_N)) u_merge (
        .levels  (line_lvl),
        .routes  (line_route),
        .irq_out (ctl_irq)
    );

    // R6/R7: an OR merge never raises more inputs than there are high lines
    assert_no_extra_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctl_irq) <= $countones(line_lvl));

    assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_lvl == '0) |-> (ctl_irq == '0));

    for (genvar p = 0; p < LINE_N; p++) begin : g_chk
        assert_unrouted_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (line_route[p] >= 8'(OUT_N) && line_lvl == LINE_N'(1 << p)) |-> (ctl_irq == '0));
        assert_routed_reaches_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (line_route[p] < 8'(OUT_N) && line_lvl[p]) |-> ctl_irq[line_route[p][3:0]]);
    end
endmodule

// File: tb/tb_irq_pin_router.sv
module tb_irq_pin_router;
    localparam int CLK_PERIOD = 10;

    logic clk = 0;
    logic rst_n = 0;
    logic dev_valid = 0;
    logic [7:0] dev_devfn = 0;
    logic [1:0] dev_pin = 0;
    logic dev_level = 0;
    logic reg_we = 0;
    logic [7:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata, alt_rdata;
    logic [15:0] ctl_irq, alt_irq;

    int tests = 0;
    int fails = 0;
    logic [3:0] m_lvl;
    logic [7:0] m_rt [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pin_router #(.OUT_N(16), .RESET_PROFILE(0)) dut (
        .clk(clk), .rst_n(rst_n), .dev_valid(dev_valid), .dev_devfn(dev_devfn),
        .dev_pin(dev_pin), .dev_level(dev_level), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_irq(ctl_irq));

    irq_pin_router #(.OUT_N(16), .RESET_PROFILE(1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .dev_valid(dev_valid), .dev_devfn(dev_devfn),
        .dev_pin(dev_pin), .dev_level(dev_level), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(alt_rdata), .ctl_irq(alt_irq));

    function automatic logic [15:0] model_out();
        logic [15:0] v = '0;
        for (int p = 0; p < 4; p++)
            if (m_lvl[p] && m_rt[p] < 8'd16) v[m_rt[p][3:0]] = 1'b1;
        return v;
    endfunction

    task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic dev_event(int slot, int pin, logic lvl);
        @(negedge clk);
        dev_valid = 1;
        dev_devfn = 8'((slot << 3) | ((slot + pin) & 7));
        dev_pin   = 2'(pin);
        dev_level = lvl;
        @(negedge clk);
        dev_valid = 0;
        m_lvl[(pin + slot + 3) % 4] = lvl;
    endtask

    task automatic reg_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        if (a >= 8'h60 && a <= 8'h63) m_rt[a - 8'h60] = d;
    endtask

    task automatic reg_read(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_levels();
        for (int p = 0; p < 4; p++) dev_event(p + 1, 0, 1'b0); // slot p+1 pin 0 -> line p
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        m_lvl = '0;
        for (int p = 0; p < 4; p++) m_rt[p] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R8: reset state of both profiles
        check16("R8 reset outputs", ctl_irq, 16'h0);
        check16("R8 alt reset outputs", alt_irq, 16'h0);
        for (int p = 0; p < 4; p++) begin
            reg_read(8'(8'h60 + p), rd);
            check8("R8 profile0 route", rd, 8'h80);
            #1 check8("R8 profile1 route", alt_rdata, (p < 2) ? 8'h0A : 8'h0B);
        end
        // R8: profile 1 steers A,B to 10 and C,D to 11
        dev_event(1, 1, 1'b1); // line B
        check16("R8 alt line B to 10", alt_irq, 16'h0400);
        check16("R5 profile0 line B disconnected", ctl_irq, 16'h0);
        dev_event(1, 3, 1'b1); // line D
        check16("R8 alt line D to 11", alt_irq, 16'h0C00);
        clear_levels();
        check16("R2 levels cleared", ctl_irq, 16'h0);

        // R1: exhaustive slot/pin sweep with one-hot routing
        for (int p = 0; p < 4; p++) reg_write(8'(8'h60 + p), 8'(p));
        for (int s = 0; s < 32; s++) begin
            for (int pn = 0; pn < 4; pn++) begin
                dev_event(s, pn, 1'b1);
                check16("R1 swizzle assert", ctl_irq, 16'(1 << ((pn + s + 3) % 4)));
                dev_event(s, pn, 1'b0);
                check16("R1 swizzle release", ctl_irq, 16'h0);
            end
        end

        // R2: other lines keep their level; idle cycles change nothing
        dev_event(1, 0, 1'b1);
        dev_event(3, 0, 1'b1);
        repeat (3) @(negedge clk);
        check16("R2 hold", ctl_irq, model_out());
        dev_event(1, 0, 1'b0);
        check16("R2 others unchanged", ctl_irq, 16'h0004);
        clear_levels();

        // R4/R5: every routing value for every line, plus out-of-range values
        for (int p = 0; p < 4; p++) begin
            for (int q = 0; q < 4; q++) reg_write(8'(8'h60 + q), 8'h80);
            dev_event(p + 1, 0, 1'b1);
            for (int v = 0; v < 20; v++) begin
                reg_write(8'(8'h60 + p), 8'(v));
                check16((v < 16) ? "R4 route value" : "R5 value >= 16", ctl_irq, model_out());
            end
            reg_write(8'(8'h60 + p), 8'h85);
            check16("R5 bit7 disconnect", ctl_irq, 16'h0);
            reg_read(8'(8'h60 + p), rd);
            check8("R3 readback", rd, 8'h85);
            dev_event(p + 1, 0, 1'b0);
        end

        // R6: OR merge of lines sharing an input
        reg_write(8'h60, 8'd5);
        reg_write(8'h62, 8'd5);
        dev_event(1, 0, 1'b1);
        check16("R6 A only", ctl_irq, 16'h0020);
        dev_event(3, 0, 1'b1);
        check16("R6 A and C", ctl_irq, 16'h0020);
        dev_event(1, 0, 1'b0);
        check16("R6 C keeps input high", ctl_irq, 16'h0020);
        dev_event(3, 0, 1'b0);
        check16("R7 none high", ctl_irq, 16'h0);
        for (int p = 0; p < 4; p++) reg_write(8'(8'h60 + p), 8'd9);
        for (int p = 0; p < 4; p++) begin
            dev_event(p + 1, 0, 1'b1);
            check16("R6 all to 9", ctl_irq, 16'h0200);
        end
        clear_levels();

        // R9: moving a live route drops the old input
        reg_write(8'h60, 8'd3);
        reg_write(8'h61, 8'd12);
        dev_event(1, 0, 1'b1);
        dev_event(2, 0, 1'b1);
        check16("R9 before move", ctl_irq, 16'h1008);
        reg_write(8'h60, 8'd7);
        check16("R9 after move", ctl_irq, 16'h1080);

        // R3: stray writes and reads
        reg_write(8'h64, 8'h01);
        reg_write(8'h5F, 8'h02);
        check16("R3 stray write no output effect", ctl_irq, 16'h1080);
        reg_read(8'h64, rd);
        check8("R3 stray read zero", rd, 8'h00);
        reg_read(8'h60, rd);
        check8("R3 route A intact", rd, 8'd7);
        reg_read(8'h61, rd);
        check8("R3 route B intact", rd, 8'd12);

        // R7: unselected inputs low with everything unrouted
        for (int p = 0; p < 4; p++) reg_write(8'(8'h60 + p), 8'hFF);
        dev_event(3, 0, 1'b1);
        check16("R7 all unrouted", ctl_irq, 16'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule